// File: doc/BRIEF.md
# Ethernet Receive Frame Status Classifier

This block sits behind the receive side of an Ethernet MAC and watches the byte stream of each arriving frame. The stream starts at the destination address. Start, end, receive-error, CRC-result and dribble strobes come with the bytes. While a frame streams in, the block captures the header bytes it needs and counts the bytes. On the last beat it turns the frame into one packed 32-bit status word. The upper half of that word is the byte count. The lower bits are event flags: reception complete, multicast, broadcast, dribble nibble, control frame, pause frame, unknown control opcode, VLAN tag match and length error.

The status word sits in a register that is rewritten whenever a frame finishes. A small register port gives access to it. The same port reaches a per-flag interrupt mask, the VLAN tag-protocol value to match, and a control bit that turns on clear-on-read. An active-low interrupt stays asserted while any unmasked flag is set in the status register.

The byte input is a valid/ready stream. The block never applies back-pressure: `rx_ready` goes high on the first clock after reset and stays high. A beat is taken on every clock where `rx_valid` and `rx_ready` are both high. No beat is ever stalled or dropped, so upstream logic may tie its stall path off. The register port and the interrupt are plain signals.

Top module: `rx_frame_status`

## Requirements
- R1: `rx_ready` is 1 from the first clock after reset. A frame begins on an accepted beat with `rx_sof`=1. Accepted beats that are neither inside a frame nor marked `rx_sof` change nothing.
- R2: Status bits [31:16] hold the number of bytes accepted in the last frame, counting the `rx_sof` beat, and saturate at 65535.
- R3: Status bit 8 (length error) is set when the count is below 64. It is also set when the count is above 1518, or above 1522 when the tag matched. The tag matches when the frame has at least 14 bytes and bytes 12 and 13 (big-endian) equal the VLAN-type register, which resets to 0x8100.
- R4: Status bit 7 (VLAN) is set on a tag match, unless the CRC was bad or `rx_err` was high on any beat of the frame.
- R5: Status bit 4 (control) is set when bytes 12–13 equal 0x8808. Bit 5 (pause) is set when such a frame also has opcode 0x0001 in bytes 14–15. Bit 6 (unknown opcode) is set for any other control frame. All three are 0 when `rx_crc_bad` was high on the end beat.
- R6: Status bit 2 (broadcast) is set when bytes 0–5 are all 0xFF. Bit 1 (multicast) is set when bit 0 of byte 0 is 1, which includes broadcast.
- R7: Status bit 3 (dribble) copies `rx_dribble` from the end beat.
- R8: Status bit 0 (complete) is set at end of frame unless the CRC was bad or a receive error was seen.
- R9: The status register takes the new word on the clock that accepts the end beat. It holds between frames, and register writes to it are ignored.
- R10: `irq_n` is 0 one clock after the status register holds a flag in bits 8:0 whose mask bit (register 1, bits 8:0) is 0, and 1 otherwise. A masked event still sets its status bit.
- R11: When bit 0 of control register 3 is 1, a read of register 0 returns the status and clears the whole register. A frame end in the same clock takes precedence and loads the new word. When the bit is 0, reads do not clear.
- R12: The register map is 0 status, 1 mask, 2 VLAN type (bits 15:0), 3 control. Read data appears on `reg_rdata` on the clock after `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_ready | output | 1 | Beat accepted; high from the first clock after reset |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Receive error on this beat |
| rx_crc_bad | input | 1 | CRC check failed, qualified by the end beat |
| rx_dribble | input | 1 | Extra half byte at frame end, qualified by the end beat |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench drives frames that sit exactly on the length limits: 63/64, 1518/1519 untagged and 1522/1523 tagged. A classifier with an off-by-one comparison, or one that ignores the tag when choosing the upper limit, flags a legal frame or misses an illegal one. Pause and unknown-opcode control frames go in both with a good CRC and with a bad one. A tagged frame also carries a receive error, so a design that forgets to gate VLAN, complete or control flags on errors reports them anyway. The tests also cover masked events and clear-on-read, including a read that lands on the same clock as a frame end. Further checks send stray beats outside any frame and write to the status register. A design that gets these wrong either leaves the interrupt stuck, loses a fresh status word, or lets the stray input corrupt the register.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CNT_W      = 16;
  localparam int NFLAG      = 9;
  localparam int ADDR_BYTES = 6;
  localparam int TYPE_OFS   = 12;
  localparam int OP_OFS     = 14;

  localparam int B_DONE  = 0;
  localparam int B_MCAST = 1;
  localparam int B_BCAST = 2;
  localparam int B_DRIB  = 3;
  localparam int B_CTRL  = 4;
  localparam int B_PAUSE = 5;
  localparam int B_UNKOP = 6;
  localparam int B_VLAN  = 7;
  localparam int B_LENER = 8;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_MASK   = 2'd1;
  localparam logic [1:0] A_VTYPE  = 2'd2;
  localparam logic [1:0] A_CTRL   = 2'd3;

  typedef struct packed {
    logic [15:0] tpid;
    logic [15:0] opcode;
    logic        bcast;
    logic        mcast;
    logic        err_seen;
  } hdr_t;
endpackage

// File: rtl/rxs_hdr_track.sv
module rxs_hdr_track
  import rxs_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          sof,
  input  logic          eof,
  input  logic          err,
  input  logic [7:0]    data,
  output hdr_t          hdr_nxt,
  output logic [CW-1:0] cnt_nxt,
  output logic          frame_end
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          in_frame_q;
  logic [CW-1:0] cnt_q;
  hdr_t          hdr_q;
  logic          live;
  logic [CW-1:0] pos;

  always_comb begin
    live    = beat && (in_frame_q || sof);
    pos     = sof ? '0 : cnt_q;
    hdr_nxt = sof ? '0 : hdr_q;
    cnt_nxt = pos;
    if (live) begin
      cnt_nxt = (pos == CNT_MAX) ? pos : pos + CW'(1);
      hdr_nxt.err_seen = hdr_nxt.err_seen | err;
      if (pos == '0) begin
        hdr_nxt.bcast = (data == 8'hFF);
        hdr_nxt.mcast = data[0];
      end else if (pos < CW'(ADDR_BYTES)) begin
        hdr_nxt.bcast = hdr_nxt.bcast & (data == 8'hFF);
      end
      if (pos == CW'(TYPE_OFS))     hdr_nxt.tpid[15:8]   = data;
      if (pos == CW'(TYPE_OFS + 1)) hdr_nxt.tpid[7:0]    = data;
      if (pos == CW'(OP_OFS))       hdr_nxt.opcode[15:8] = data;
      if (pos == CW'(OP_OFS + 1))   hdr_nxt.opcode[7:0]  = data;
    end
  end

  assign frame_end = live && eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      hdr_q      <= '0;
    end else if (live) begin
      in_frame_q <= !eof;
      cnt_q      <= cnt_nxt;
      hdr_q      <= hdr_nxt;
    end
  end
endmodule

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
#(
  parameter int          CW         = CNT_W,
  parameter int          MIN_LEN    = 64,
  parameter int          MAX_LEN    = 1518,
  parameter int          TAG_EXTRA  = 4,
  parameter logic [15:0] CTRL_TYPE  = 16'h8808,
  parameter logic [15:0] PAUSE_OP   = 16'h0001
) (
  input  hdr_t          hdr,
  input  logic [CW-1:0] cnt,
  input  logic          crc_bad,
  input  logic          dribble,
  input  logic [15:0]   vtype,
  output logic [31:0]   status
);
  localparam logic [CW-1:0] LIM_PLAIN = CW'(MAX_LEN);
  localparam logic [CW-1:0] LIM_TAG   = CW'(MAX_LEN + TAG_EXTRA);
  localparam logic [CW-1:0] LIM_MIN   = CW'(MIN_LEN);

  logic          have_type, have_op, have_da, tag_ok, bad_rx, is_ctrl, is_pause;
  logic [CW-1:0] lim;

  always_comb begin
    have_type = cnt >= CW'(TYPE_OFS + 2);
    have_op   = cnt >= CW'(OP_OFS + 2);
    have_da   = cnt >= CW'(ADDR_BYTES);
    tag_ok    = have_type && (hdr.tpid == vtype);
    lim       = tag_ok ? LIM_TAG : LIM_PLAIN;
    bad_rx    = crc_bad || hdr.err_seen;
    is_ctrl   = have_type && (hdr.tpid == CTRL_TYPE) && !crc_bad;
    is_pause  = is_ctrl && have_op && (hdr.opcode == PAUSE_OP);

    status          = '0;
    status[31:16]   = 16'(cnt);
    status[B_DONE]  = !bad_rx;
    status[B_MCAST] = (cnt != '0) && hdr.mcast;
    status[B_BCAST] = have_da && hdr.bcast;
    status[B_DRIB]  = dribble;
    status[B_CTRL]  = is_ctrl;
    status[B_PAUSE] = is_pause;
    status[B_UNKOP] = is_ctrl && !is_pause;
    status[B_VLAN]  = tag_ok && !bad_rx;
    status[B_LENER] = (cnt < LIM_MIN) || (cnt > lim);
  end
endmodule

// File: rtl/rxs_regs.sv
module rxs_regs
  import rxs_pkg::*;
#(
  parameter logic [15:0] VTYPE_RST = 16'h8100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [31:0]      new_status,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_n,
  output logic [31:0]      status_q,
  output logic [NFLAG-1:0] mask_q,
  output logic [15:0]      vtype_q,
  output logic             cor_q
);
  logic [NFLAG-1:0] live_evt;
  logic             irq_q;
  logic             rd_clear;
  logic [31:0]      rd_mux;

  for (genvar i = 0; i < NFLAG; i++) begin : g_evt
    assign live_evt[i] = status_q[i] & ~mask_q[i];
  end

  assign rd_clear = reg_rd && (reg_addr == A_STATUS) && cor_q;

  always_comb begin
    unique case (reg_addr)
      A_STATUS: rd_mux = status_q;
      A_MASK:   rd_mux = 32'(mask_q);
      A_VTYPE:  rd_mux = 32'(vtype_q);
      default:  rd_mux = 32'(cor_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      mask_q    <= '0;
      vtype_q   <= VTYPE_RST;
      cor_q     <= 1'b0;
      reg_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (frame_end)     status_q <= new_status;
      else if (rd_clear) status_q <= '0;
      if (reg_wr) begin
        case (reg_addr)
          A_MASK:  mask_q  <= reg_wdata[NFLAG-1:0];
          A_VTYPE: vtype_q <= reg_wdata[15:0];
          A_CTRL:  cor_q   <= reg_wdata[0];
          default: ;
        endcase
      end
      if (reg_rd) reg_rdata <= rd_mux;
      irq_q <= |live_evt;
    end
  end

  assign irq_n = ~irq_q;
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rxs_pkg::*;
#(
  parameter int          MIN_LEN   = 64,
  parameter int          MAX_LEN   = 1518,
  parameter int          TAG_EXTRA = 4,
  parameter logic [15:0] VTYPE_RST = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_err,
  input  logic        rx_crc_bad,
  input  logic        rx_dribble,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_n
);
  logic             rdy_q;
  logic             beat;
  hdr_t             hdr_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             frame_end;
  logic [31:0]      new_status;
  logic [31:0]      status_q;
  logic [NFLAG-1:0] mask_q;
  logic [15:0]      vtype_q;
  logic             cor_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign rx_ready = rdy_q;
  assign beat     = rx_valid && rdy_q;

  rxs_hdr_track #(.CW(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(rx_sof), .eof(rx_eof),
    .err(rx_err), .data(rx_data), .hdr_nxt(hdr_nxt), .cnt_nxt(cnt_nxt),
    .frame_end(frame_end)
  );

  rxs_classify #(
    .CW(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .TAG_EXTRA(TAG_EXTRA)
  ) u_cls (
    .hdr(hdr_nxt), .cnt(cnt_nxt), .crc_bad(rx_crc_bad), .dribble(rx_dribble),
    .vtype(vtype_q), .status(new_status)
  );

  rxs_regs #(.VTYPE_RST(VTYPE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .new_status(new_status),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n), .status_q(status_q), .mask_q(mask_q),
    .vtype_q(vtype_q), .cor_q(cor_q)
  );
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        frame_end,
  input logic        crc_bad,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic        cor,
  input logic [8:0]  mask,
  input logic [31:0] status,
  input logic        irq_n
);
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rx_ready);

  p_crc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && crc_bad) |=>
      (status[4] == 1'b0 && status[5] == 1'b0 && status[6] == 1'b0));

  p_crc_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && crc_bad) |=> (status[0] == 1'b0 && status[7] == 1'b0));

  p_ctrl_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] || status[6]) |-> (status[4] && !(status[5] && status[6])));

  p_bcast_mcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[1]);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !(reg_rd && reg_addr == 2'd0 && cor)) |=> $stable(status));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == !(|($past(status[8:0]) & ~$past(mask)))));

  p_cor_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && cor && !frame_end) |=> (status == 32'd0));
endmodule

bind rx_frame_status rxs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .frame_end(frame_end),
  .crc_bad(rx_crc_bad), .reg_rd(reg_rd), .reg_addr(reg_addr), .cor(cor_q),
  .mask(mask_q), .status(status_q), .irq_n(irq_n)
);

// File: tb/rx_frame_status_tb.sv
module rx_frame_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        rx_sof = 1'b0;
  logic        rx_eof = 1'b0;
  logic        rx_err = 1'b0;
  logic        rx_crc_bad = 1'b0;
  logic        rx_dribble = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  fbuf [0:1599];
  logic [8:0]  mask_sh = '0;
  logic [15:0] vtype_sh = 16'h8100;
  logic [31:0] exp_st = '0;

  always #10 clk = ~clk;

  rx_frame_status u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_crc_bad(rx_crc_bad), .rx_dribble(rx_dribble), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int len, input bit crc, input bit err, input bit drib);
    logic [31:0] s;
    logic [15:0] tp;
    bit tag, ct, pa, bc;
    int lim;
    s = '0;
    s[31:16] = (len > 65535) ? 16'hFFFF : 16'(len);
    tp = (len >= 14) ? {fbuf[12], fbuf[13]} : 16'h0000;
    tag = (len >= 14) && (tp == vtype_sh);
    lim = tag ? 1522 : 1518;
    bc = (len >= 6);
    for (int i = 0; i < 6; i++) if (i < len && fbuf[i] != 8'hFF) bc = 0;
    ct = (len >= 14) && (tp == 16'h8808) && !crc;
    pa = ct && (len >= 16) && ({fbuf[14], fbuf[15]} == 16'h0001);
    s[0] = !crc && !err;
    s[1] = (len >= 1) && fbuf[0][0];
    s[2] = bc;
    s[3] = drib;
    s[4] = ct;
    s[5] = pa;
    s[6] = ct && !pa;
    s[7] = tag && !crc && !err;
    s[8] = (len < 64) || (len > lim);
    return s;
  endfunction

  function automatic logic exp_irq(input logic [31:0] st);
    return !(|(st[8:0] & ~mask_sh));
  endfunction

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) fbuf[i] = 8'(i) ^ 8'h5A;
    fbuf[0] = 8'h02;
  endtask

  task automatic set_type(input logic [15:0] t);
    fbuf[12] = t[15:8];
    fbuf[13] = t[7:0];
  endtask

  task automatic send(input int len, input bit crc, input int err_at, input bit drib,
                      input bit use_sof, input bit rd_at_end);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid   = 1'b1;
      rx_data    = fbuf[i];
      rx_sof     = use_sof && (i == 0);
      rx_eof     = (i == len - 1);
      rx_err     = (i == err_at);
      rx_crc_bad = (i == len - 1) && crc;
      rx_dribble = (i == len - 1) && drib;
      if (rd_at_end && i == len - 1) begin
        reg_rd = 1'b1;
        reg_addr = 2'd0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    rx_crc_bad = 1'b0; rx_dribble = 1'b0; reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic frame_check(input string req, input int len, input bit crc,
                             input int err_at, input bit drib);
    logic [31:0] d;
    send(len, crc, err_at, drib, 1'b1, 1'b0);
    exp_st = model(len, crc, err_at >= 0, drib);
    chk({req, " irq"}, 32'(irq_n), 32'(exp_irq(exp_st)));
    reg_read(2'd0, d);
    chk(req, d, exp_st);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 ready", 32'(rx_ready), 32'd1);
    chk("R10 irq idle", 32'(irq_n), 32'd1);
    reg_read(2'd0, d); chk("R12 status rst", d, 32'd0);
    reg_read(2'd1, d); chk("R12 mask rst", d, 32'd0);
    reg_read(2'd2, d); chk("R3 vtype rst", d, 32'h0000_8100);
    reg_read(2'd3, d); chk("R11 ctrl rst", d, 32'd0);
  endtask

  task automatic t_unicast;
    fill(64); set_type(16'h0800);
    frame_check("R2 R8 unicast64", 64, 0, -1, 0);
  endtask

  task automatic t_bcast;
    fill(100); set_type(16'h0800);
    for (int i = 0; i < 6; i++) fbuf[i] = 8'hFF;
    frame_check("R6 broadcast", 100, 0, -1, 0);
    fill(80); set_type(16'h0800);
    for (int i = 0; i < 5; i++) fbuf[i] = 8'hFF;
    fbuf[5] = 8'hFE;
    frame_check("R6 near-broadcast", 80, 0, -1, 0);
  endtask

  task automatic t_mcast_short;
    fill(63); set_type(16'h0800);
    fbuf[0] = 8'h01; fbuf[1] = 8'h00; fbuf[2] = 8'h5E;
    frame_check("R3 R6 mcast63", 63, 0, -1, 0);
  endtask

  task automatic t_lengths;
    fill(1519); set_type(16'h0800);
    frame_check("R3 plain1518", 1518, 0, -1, 0);
    frame_check("R3 plain1519", 1519, 0, -1, 0);
    fill(1523); set_type(16'h8100);
    frame_check("R3 R4 tag1522", 1522, 0, -1, 0);
    frame_check("R3 tag1523", 1523, 0, -1, 0);
  endtask

  task automatic t_vtype_prog;
    reg_write(2'd2, 32'h0000_88A8);
    vtype_sh = 16'h88A8;
    fill(70); set_type(16'h88A8);
    frame_check("R4 prog vtype", 70, 0, -1, 0);
    set_type(16'h8100);
    frame_check("R4 old vtype", 70, 0, -1, 0);
    reg_write(2'd2, 32'h0000_8100);
    vtype_sh = 16'h8100;
  endtask

  task automatic t_control;
    fill(64); set_type(16'h8808);
    fbuf[0] = 8'h01; fbuf[14] = 8'h00; fbuf[15] = 8'h01;
    frame_check("R5 pause", 64, 0, -1, 0);
    frame_check("R5 pause crcbad", 64, 1, -1, 0);
    fbuf[15] = 8'h05;
    frame_check("R5 unknown op", 64, 0, -1, 0);
    frame_check("R5 unknown crcbad", 64, 1, -1, 0);
  endtask

  task automatic t_errors;
    fill(90); set_type(16'h8100);
    frame_check("R4 R8 rxerr", 90, 0, 30, 0);
    frame_check("R4 R8 crcbad", 90, 1, -1, 0);
  endtask

  task automatic t_dribble;
    fill(65); set_type(16'h0800);
    frame_check("R7 dribble", 65, 0, -1, 1);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    reg_write(2'd1, 32'h0000_01FF); mask_sh = 9'h1FF;
    fill(64); set_type(16'h0800);
    frame_check("R10 all masked", 64, 0, -1, 0);
    reg_write(2'd1, 32'h0000_01FE); mask_sh = 9'h1FE;
    chk("R10 unmask done", 32'(irq_n), 32'd0);
    reg_read(2'd1, d); chk("R12 mask rd", d, 32'h0000_01FE);
    reg_write(2'd1, 32'd0); mask_sh = '0;
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, d); chk("R9 write ignored", d, exp_st);
    reg_read(2'd0, d); chk("R11 no cor clear", d, exp_st);
    fill(70); fbuf[0] = 8'hFF;
    send(70, 1'b1, 5, 1'b1, 1'b0, 1'b0);
    reg_read(2'd0, d); chk("R1 stray beats", d, exp_st);
  endtask

  task automatic t_cor;
    logic [31:0] d;
    reg_write(2'd3, 32'd1);
    reg_read(2'd0, d); chk("R11 cor value", d, exp_st);
    reg_read(2'd0, d); chk("R11 cor cleared", d, 32'd0);
    @(negedge clk);
    chk("R10 irq after clear", 32'(irq_n), 32'd1);
    fill(64); set_type(16'h0800);
    send(64, 1'b0, -1, 1'b0, 1'b1, 1'b1);
    exp_st = model(64, 0, 0, 0);
    chk("R11 rd with end rdata", reg_rdata, 32'd0);
    reg_write(2'd3, 32'd0);
    reg_read(2'd0, d); chk("R11 frame end wins", d, exp_st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_unicast;
    t_bcast;
    t_mcast_short;
    t_lengths;
    t_vtype_prog;
    t_control;
    t_errors;
    t_dribble;
    t_mask;
    t_ignore;
    t_cor;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule